// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Status Register

This block is the arithmetic and logic unit of an accumulator-based 8-bit CPU. Each cycle it takes the accumulator value, a temporary operand and a 4-bit operation code. It returns a combinational result for the datapath to write back, together with a result write-enable. It also holds a five-bit status register with sign, zero, half (nibble) carry, even parity and carry. When an operation needs the carry, it takes it from this register.

Addition and subtraction share one adder. Each can include the stored carry, as a carry-in or as a borrow-in. Compare runs the subtraction only to set the status bits and does not raise the write-enable. The bitwise operations, the single-bit rotates and the complement all act on the accumulator. Increment and decrement act on the temporary operand. The status register loads on a clock edge only while the enable is high and the code is a defined operation. An asynchronous active-low reset clears it.

Top module: `alu8_core`

## Requirements
- R1: While reset is asserted, and at the first sample after its release, all five status flags read 0.
- R2: Code 0 (add) yields (acc + opnd) mod 256 and code 1 (add with carry) yields (acc + opnd + stored carry) mod 256. Carry is set when the true sum exceeds 255.
- R3: Code 2 (subtract) yields (acc - opnd) mod 256 and code 3 (subtract with borrow) yields (acc - opnd - stored carry) mod 256. Carry is set when the true difference is negative.
- R4: The half-carry flag is the carry out of bit 3 for add-type operations and the borrow out of bit 3 for subtract, compare and decrement. It is computed on the low nibbles, including the stored carry where the operation uses it.
- R5: For every operation that writes status except the rotates, sign equals bit 7 of the value the flags describe. Zero is set when that value is 0x00. Parity is set when that value has an even count of one bits.
- R6: Code 4 (AND), code 5 (XOR) and code 6 (OR) yield the bitwise result and clear both carry and half carry.
- R7: Code 7 (compare) sets all five flags as subtract would, keeps the write-enable low and presents the accumulator unchanged on the result.
- R8: Code 8 rotates the accumulator left: bit 7 moves to bit 0 and into carry. Code 9 rotates it right: bit 0 moves to bit 7 and into carry. Sign, zero, half carry and parity keep their values.
- R9: Code 10 yields the bitwise complement of the accumulator and leaves all five flags unchanged.
- R10: Code 11 yields opnd + 1 and code 12 yields opnd - 1, both mod 256. Sign, zero, parity and half carry update, and carry keeps its value.
- R11: While the enable is low, or for codes 13 to 15, the write-enable stays low and no flag changes. For codes 0 to 6 and 8 to 12 with the enable high, the write-enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_en | input | 1 | Operation enable for this cycle |
| alu_op | input | 4 | Operation code (0..12 defined) |
| acc_in | input | 8 | Accumulator operand |
| tmp_in | input | 8 | Temporary operand (target of increment/decrement) |
| result | output | 8 | Combinational result |
| res_we | output | 1 | Result write-enable |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Half (nibble) carry flag |
| flag_p | output | 1 | Even parity flag |
| flag_cy | output | 1 | Carry / borrow flag |

## Verification
The bound assertions check on every cycle these properties:
- the status register holds still when idle or given an undefined code;
- compare never raises the write-enable;
- zero and parity track the previous result;
- rotates move the right bit into carry and leave the other flags alone;
- increment/decrement keep carry;
- the bitwise operations clear carry and half carry.

The exact sums and differences, the half-carry values and the use of the stored carry in the chained add and subtract operations can only be shown by the bench's sweep. The sweep compares every operation against an arithmetic model, and the model carries its status bits from one operation to the next.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_RLC = 4'd8,
    OP_RRC = 4'd9,
    OP_CMA = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         hcout
);
  localparam int H = W / 2;

  logic [W:0] full;
  logic [H:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      half = {1'b0, a[H-1:0]} - {1'b0, b[H-1:0]} - {{H{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      half = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
    end
  end

  assign res   = full[W-1:0];
  assign cout  = full[W];
  assign hcout = half[H];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_OR:   res = a | b;
      OP_RLC:  res = {a[W-2:0], a[W-1]};
      OP_RRC:  res = {a[0], a[W-1:1]};
      OP_CMA:  res = ~a;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  alu_flags_t d,
  output alu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alu_en,
  input  logic [3:0]   alu_op,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] tmp_in,
  output logic [W-1:0] result,
  output logic         res_we,
  output logic         flag_s,
  output logic         flag_z,
  output logic         flag_ac,
  output logic         flag_p,
  output logic         flag_cy
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  alu_flags_t fq, fd;
  logic [W-1:0] as_a, as_b, as_res, lg_res, szp_val;
  logic as_sub, as_cin, as_co, as_hc;
  logic op_valid, writes;

  // operand steering for the shared adder
  always_comb begin
    as_a   = acc_in;
    as_b   = tmp_in;
    as_sub = 1'b0;
    as_cin = 1'b0;
    case (alu_op)
      OP_ADC: as_cin = fq.cy;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin as_sub = 1'b1; as_cin = fq.cy; end
      OP_INC: begin as_a = tmp_in; as_b = ONE; end
      OP_DEC: begin as_a = tmp_in; as_b = ONE; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a(as_a), .b(as_b), .sub(as_sub), .cin(as_cin),
    .res(as_res), .cout(as_co), .hcout(as_hc)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(alu_op), .a(acc_in), .b(tmp_in), .res(lg_res)
  );

  // result select and next-flag computation
  always_comb begin
    result   = acc_in;
    writes   = 1'b0;
    op_valid = 1'b1;
    szp_val  = as_res;
    fd       = fq;
    case (alu_op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        result = as_res;
        writes = 1'b1;
        fd.ac  = as_hc;
        fd.cy  = as_co;
      end
      OP_CMP: begin
        fd.ac = as_hc;
        fd.cy = as_co;
      end
      OP_AND, OP_XOR, OP_OR: begin
        result  = lg_res;
        writes  = 1'b1;
        szp_val = lg_res;
        fd.ac   = 1'b0;
        fd.cy   = 1'b0;
      end
      OP_RLC: begin
        result = lg_res;
        writes = 1'b1;
        fd.cy  = acc_in[W-1];
      end
      OP_RRC: begin
        result = lg_res;
        writes = 1'b1;
        fd.cy  = acc_in[0];
      end
      OP_CMA: begin
        result = lg_res;
        writes = 1'b1;
      end
      OP_INC, OP_DEC: begin
        result = as_res;
        writes = 1'b1;
        fd.ac  = as_hc;
      end
      default: op_valid = 1'b0;
    endcase
    if (op_valid && alu_op != OP_RLC && alu_op != OP_RRC && alu_op != OP_CMA) begin
      fd.s = szp_val[W-1];
      fd.z = ~|szp_val;
      fd.p = ~^szp_val;
    end
  end

  assign res_we = alu_en & writes;

  alu8_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .load(alu_en & op_valid), .d(fd), .q(fq)
  );

  assign flag_s  = fq.s;
  assign flag_z  = fq.z;
  assign flag_ac = fq.ac;
  assign flag_p  = fq.p;
  assign flag_cy = fq.cy;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         alu_en,
  input logic [3:0]   alu_op,
  input logic         acc_msb,
  input logic         acc_lsb,
  input logic [W-1:0] result,
  input logic         res_we,
  input logic         flag_s,
  input logic         flag_z,
  input logic         flag_ac,
  input logic         flag_p,
  input logic         flag_cy
);
  logic [4:0] fl;
  assign fl = {flag_s, flag_z, flag_ac, flag_p, flag_cy};

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> fl == 5'b0);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en || alu_op > 4'd12) |=> $stable(fl));

  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en || alu_op > 4'd12) |-> !res_we);

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && alu_op == 4'd7) |-> !res_we);

  assert_zero_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && (alu_op <= 4'd6 || alu_op == 4'd11 || alu_op == 4'd12))
      |=> flag_z == ($past(result) == '0));

  assert_parity_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && (alu_op <= 4'd6 || alu_op == 4'd11 || alu_op == 4'd12))
      |=> flag_p == ~^$past(result));

  assert_rotl_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && alu_op == 4'd8)
      |=> flag_cy == $past(acc_msb) && $stable({flag_s, flag_z, flag_ac, flag_p}));

  assert_rotr_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && alu_op == 4'd9)
      |=> flag_cy == $past(acc_lsb) && $stable({flag_s, flag_z, flag_ac, flag_p}));

  assert_cma_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && alu_op == 4'd10) |=> $stable(fl));

  assert_incdec_keeps_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && (alu_op == 4'd11 || alu_op == 4'd12)) |=> $stable(flag_cy));

  assert_logic_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && alu_op >= 4'd4 && alu_op <= 4'd6) |=> !flag_cy && !flag_ac);

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .alu_op(alu_op),
  .acc_msb(acc_in[W-1]), .acc_lsb(acc_in[0]), .result(result), .res_we(res_we),
  .flag_s(flag_s), .flag_z(flag_z), .flag_ac(flag_ac), .flag_p(flag_p),
  .flag_cy(flag_cy)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_en = 1'b0;
  logic [3:0] alu_op = 4'd0;
  logic [7:0] acc_in = 8'd0;
  logic [7:0] tmp_in = 8'd0;
  logic [7:0] result;
  logic       res_we, flag_s, flag_z, flag_ac, flag_p, flag_cy;

  int errors = 0;
  int checks = 0;
  logic [4:0] mf = 5'b0;  // model flags {s,z,ac,p,cy}

  always #5 clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .alu_op(alu_op),
    .acc_in(acc_in), .tmp_in(tmp_in), .result(result), .res_we(res_we),
    .flag_s(flag_s), .flag_z(flag_z), .flag_ac(flag_ac), .flag_p(flag_p),
    .flag_cy(flag_cy)
  );

  task automatic chk(input string tag, input logic ok, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%0d acc=%h opnd=%h en=%0b: got %h expected %h",
               tag, alu_op, acc_in, tmp_in, alu_en, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5, 6: return "R6";
      7:       return "R7";
      8, 9:    return "R8";
      10:      return "R9";
      11, 12:  return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input int op, input logic [7:0] a, input logic [7:0] b,
                     input logic en);
    int av, bv, c, t, h;
    logic [7:0] r, er;
    logic ew, valid, szp, s_ac, s_cy;
    logic [4:0] nf;
    av = a; bv = b; c = mf[0];
    t = 0; h = 0; r = a; er = a; ew = 1'b1; valid = 1'b1; szp = 1'b1;
    s_ac = mf[2]; s_cy = mf[0];
    case (op)
      0, 1: begin
        if (op == 0) c = 0;
        t = av + bv + c; h = (av % 16) + (bv % 16) + c;
        r = t[7:0]; er = r; s_cy = (t > 255); s_ac = (h > 15);  // R4
      end
      2, 3, 7: begin
        if (op != 3) c = 0;
        t = av - bv - c; h = (av % 16) - (bv % 16) - c;
        r = t[7:0]; s_cy = (t < 0); s_ac = (h < 0);
        if (op == 7) ew = 1'b0; else er = r;
      end
      4: begin r = a & b; er = r; s_cy = 0; s_ac = 0; end
      5: begin r = a ^ b; er = r; s_cy = 0; s_ac = 0; end
      6: begin r = a | b; er = r; s_cy = 0; s_ac = 0; end
      8: begin er = {a[6:0], a[7]}; s_cy = a[7]; szp = 0; end
      9: begin er = {a[0], a[7:1]}; s_cy = a[0]; szp = 0; end
      10: begin er = ~a; szp = 0; end
      11: begin t = bv + 1; r = t[7:0]; er = r; s_ac = ((bv % 16) == 15); end
      12: begin t = bv - 1; r = t[7:0]; er = r; s_ac = ((bv % 16) == 0); end
      default: begin valid = 1'b0; ew = 1'b0; szp = 0; end
    endcase
    nf = mf;
    if (valid) begin
      nf[2] = s_ac; nf[0] = s_cy;
      if (szp) begin
        nf[4] = r[7];                 // R5 sign
        nf[3] = (r == 8'd0);          // R5 zero
        nf[1] = ~(^r);                // R5 parity
      end
    end
    if (!en) begin ew = 1'b0; nf = mf; end
    @(negedge clk);
    alu_op = op[3:0]; acc_in = a; tmp_in = b; alu_en = en;
    #2;
    if (en && valid)
      chk(tag_of(op), (result == er) && (res_we == ew), {7'd0, res_we, result},
          {7'd0, ew, er});
    else
      chk("R11", res_we == 1'b0, {15'd0, res_we}, 16'd0);
    @(posedge clk);
    #1;
    chk(en ? tag_of(op) : "R11",
        {flag_s, flag_z, flag_ac, flag_p, flag_cy} == nf,
        {11'd0, flag_s, flag_z, flag_ac, flag_p, flag_cy}, {11'd0, nf});
    mf = nf;
  endtask

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R1", {flag_s, flag_z, flag_ac, flag_p, flag_cy} == 5'b0,
        {11'd0, flag_s, flag_z, flag_ac, flag_p, flag_cy}, 16'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", {flag_s, flag_z, flag_ac, flag_p, flag_cy} == 5'b0,
        {11'd0, flag_s, flag_z, flag_ac, flag_p, flag_cy}, 16'd0);
    mf = 5'b0;

    // directed corners: carries, borrows, nibble boundaries
    run(0, 8'hFF, 8'h01, 1'b1);   // R2 wrap to zero, carry, half carry
    run(1, 8'h00, 8'h00, 1'b1);   // R2 stored carry feeds in
    run(2, 8'h10, 8'h01, 1'b1);   // R3/R4 nibble borrow
    run(3, 8'h00, 8'h00, 1'b1);   // R3 no borrow in
    run(2, 8'h00, 8'h01, 1'b1);   // R3 borrow out
    run(3, 8'h05, 8'h05, 1'b1);   // R3 borrow-in gives FF
    run(7, 8'h42, 8'h42, 1'b1);   // R7 equal
    run(11, 8'h00, 8'h0F, 1'b1);  // R10 half carry on increment
    run(12, 8'h00, 8'h00, 1'b1);  // R10 underflow, carry kept

    // sweep every defined operation
    for (int op = 0; op <= 12; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          run(op, a[7:0], {k[3:0], a[3:0] + k[3:0]}, 1'b1);

    // R11: enable low with every code, then undefined codes enabled
    for (int i = 0; i < 48; i++)
      run(i % 16, 8'(i * 29), 8'(i * 53 + 7), 1'b0);
    for (int i = 0; i < 30; i++)
      run(13 + (i % 3), 8'(i * 71), 8'(i * 13), 1'b1);

    // R1: reset in mid-run after flags are set
    run(2, 8'h00, 8'h81, 1'b1);
    @(negedge clk);
    alu_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", {flag_s, flag_z, flag_ac, flag_p, flag_cy} == 5'b0,
        {11'd0, flag_s, flag_z, flag_ac, flag_p, flag_cy}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mf = 5'b0;
    run(8, 8'h80, 8'h00, 1'b1);   // R8 after reset

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule